// File: doc/BRIEF.md
# Path Reservation Transaction Controller

This block runs one input port of a router that works by connections. Before any payload may cross the router, the master sends a request flit asking for an output port. The controller raises a request to the output arbiter and waits. If a grant arrives, it answers the master with a positive acknowledgement and holds the reservation. If no grant arrives within a programmable number of cycles, it answers with a negative acknowledgement and goes back to idle, and the master is expected to try again later. The controller never stalls the master with back-pressure while it waits for a grant.

While the reservation holds, data flits pass straight through to the data output with a one-cycle register stage. The master closes the connection in one of two ways: it sends a last-data flit, which is forwarded, or it sends an end marker, which is not. The controller then spends one cycle in a release state, where it drops its arbiter request and pulses a release output, and returns to idle. A request that arrives while a connection is pending or open is refused at once with a negative acknowledgement. Data that arrives with no connection open is discarded and sets an error flag that stays set until reset.

Top module: `path_rsv_ctrl`

## Requirements
- R1: After synchronous reset, `arb_req`, `rel_pulse`, `ack_valid`, `dat_valid` and `err_flag` are 0 and `in_ready` is 1.
- R2: A flit has its 2-bit type in bits [23:22] (00 request, 01 data, 10 last data, 11 end marker), its header in bits [21:16] and its payload in bits [15:0]. A request flit accepted while idle raises `arb_req` from the next cycle.
- R3: An `arb_gnt` sampled while waiting for a grant gives `ack_valid`=1 with `ack_pos`=1 for one cycle on the next cycle, and `arb_req` stays high for the whole reservation.
- R4: Waiting for a grant lasts at most max(`tmo_lim`,1) cycles. If the last of them passes with no grant, the next cycle shows `ack_valid`=1 with `ack_pos`=0 and `arb_req` low. A grant sampled in that last cycle still wins.
- R5: A request flit accepted while not idle gives `ack_valid`=1 with `ack_pos`=0 on the next cycle and leaves the pending or open connection unchanged.
- R6: `in_ready` is 0 only in the cycle where waiting for a grant ends, through a grant or a timeout, and is 1 in every other cycle.
- R7: A data flit (type 01) accepted while reserved appears on the next cycle with `dat_valid`=1 and the same header and payload.
- R8: A last-data flit (type 10) accepted while reserved is forwarded as in R7. The next cycle has `rel_pulse`=1 and `arb_req`=0 for one cycle, and the controller is then idle.
- R9: An end marker (type 11) accepted while reserved is not forwarded and causes the same release as R8.
- R10: A type 01 or type 10 flit accepted while not reserved is not forwarded and sets `err_flag` from the next cycle until reset.
- R11: An end marker accepted while not reserved produces no acknowledgement, no data and no error.
- R12: `arb_gnt` has no effect unless the controller is waiting for a grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tmo_lim | input | TMO_W | Number of cycles to wait for a grant (0 behaves as 1) |
| in_valid | input | 1 | Input flit valid |
| in_ready | output | 1 | Input flit ready |
| in_flit | input | 24 | Input flit: type, header, payload |
| arb_req | output | 1 | Request to the output arbiter, held while waiting and while reserved |
| arb_gnt | input | 1 | Grant from the output arbiter |
| ack_valid | output | 1 | Acknowledgement strobe toward the master |
| ack_pos | output | 1 | 1 = positive, 0 = negative acknowledgement |
| rel_pulse | output | 1 | One-cycle release of the reserved output |
| dat_valid | output | 1 | Forwarded data strobe |
| dat_hdr | output | 6 | Forwarded header |
| dat_pay | output | 16 | Forwarded payload |
| err_flag | output | 1 | Sticky flag for data discarded outside a reservation |

## Verification
The bench targets the edges of the grant wait. It covers a grant in the very last waiting cycle, which a design with an off-by-one timer would turn into a negative acknowledgement. It covers a zero limit, which a naive counter would wrap into a wait of 256 cycles. It also covers a request that lands in the same cycle that a grant resolves, which would produce two acknowledgements at once if the input were not held off. Other targets are refused requests during an open connection, which a faulty design would let reset the reservation, and end markers and stray grants while idle, which a faulty design would turn into spurious releases or errors. A random stream with changing limits is checked cycle by cycle against a behavioural model.

// File: rtl/prc_pkg.sv
package prc_pkg;
    localparam int TYPE_W = 2;
    localparam int HDR_W  = 6;
    localparam int PAY_W  = 16;
    localparam int FLIT_W = TYPE_W + HDR_W + PAY_W;

    typedef enum logic [TYPE_W-1:0] {
        FT_REQ  = 2'b00,
        FT_DATA = 2'b01,
        FT_LAST = 2'b10,
        FT_END  = 2'b11
    } ftype_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ARB  = 2'd1,
        ST_RSV  = 2'd2,
        ST_REL  = 2'd3
    } st_e;

    typedef struct packed {
        ftype_e           ftype;
        logic [HDR_W-1:0] hdr;
        logic [PAY_W-1:0] pay;
    } flit_t;

    function automatic logic is_payload(ftype_e t);
        return (t == FT_DATA) || (t == FT_LAST);
    endfunction

    function automatic logic closes_link(ftype_e t);
        return (t == FT_LAST) || (t == FT_END);
    endfunction
endpackage

// File: rtl/prc_timer.sv
module prc_timer #(
    parameter int TMO_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [TMO_W-1:0] lim,
    output logic             expire
);
    localparam int CW = TMO_W + 1;

    logic [TMO_W-1:0] cnt;
    logic [CW-1:0]    next_cnt;

    assign next_cnt = {1'b0, cnt} + {{TMO_W{1'b0}}, 1'b1};
    assign expire   = run && (next_cnt >= {1'b0, lim});

    always_ff @(posedge clk) begin
        if (rst || !run) cnt <= '0;
        else             cnt <= next_cnt[TMO_W-1:0];
    end
endmodule

// File: rtl/prc_fsm.sv
module prc_fsm
    import prc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   acc,
    input  ftype_e ftype,
    input  logic   arb_gnt,
    input  logic   expire,
    output st_e    state,
    output logic   rdy,
    output logic   ev_grant,
    output logic   ev_nack,
    output logic   ev_fwd,
    output logic   ev_err
);
    st_e  nxt;
    logic waiting;

    assign waiting  = (state == ST_ARB);
    assign rdy      = !(waiting && (arb_gnt || expire));
    assign ev_grant = waiting && arb_gnt;
    assign ev_nack  = (waiting && !arb_gnt && expire) ||
                      (acc && ftype == FT_REQ && state != ST_IDLE);
    assign ev_fwd   = acc && state == ST_RSV && is_payload(ftype);
    assign ev_err   = acc && state != ST_RSV && is_payload(ftype);

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (acc && ftype == FT_REQ) nxt = ST_ARB;
            ST_ARB: begin
                if (arb_gnt)     nxt = ST_RSV;
                else if (expire) nxt = ST_IDLE;
            end
            ST_RSV:  if (acc && closes_link(ftype)) nxt = ST_REL;
            ST_REL:  nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

    // R4
    tmo_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ARB && expire && !arb_gnt) |=> (state == ST_IDLE));

    // R5
    busy_req_chk: assert property (@(posedge clk) disable iff (rst)
        (acc && ftype == FT_REQ && state == ST_RSV) |=> (state != ST_IDLE));
endmodule

// File: rtl/path_rsv_ctrl.sv
module path_rsv_ctrl
    import prc_pkg::*;
#(
    parameter int TMO_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [TMO_W-1:0]  tmo_lim,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [FLIT_W-1:0] in_flit,
    output logic              arb_req,
    input  logic              arb_gnt,
    output logic              ack_valid,
    output logic              ack_pos,
    output logic              rel_pulse,
    output logic              dat_valid,
    output logic [HDR_W-1:0]  dat_hdr,
    output logic [PAY_W-1:0]  dat_pay,
    output logic              err_flag
);
    flit_t f;
    st_e   state;
    logic  acc, expire, rdy;
    logic  ev_grant, ev_nack, ev_fwd, ev_err;

    assign f   = flit_t'(in_flit);
    assign acc = in_valid && rdy;

    prc_timer #(.TMO_W(TMO_W)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .run    (state == ST_ARB),
        .lim    (tmo_lim),
        .expire (expire)
    );

    prc_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .acc      (acc),
        .ftype    (f.ftype),
        .arb_gnt  (arb_gnt),
        .expire   (expire),
        .state    (state),
        .rdy      (rdy),
        .ev_grant (ev_grant),
        .ev_nack  (ev_nack),
        .ev_fwd   (ev_fwd),
        .ev_err   (ev_err)
    );

    assign in_ready  = rdy;
    assign arb_req   = (state == ST_ARB) || (state == ST_RSV);
    assign rel_pulse = (state == ST_REL);

    always_ff @(posedge clk) begin
        if (rst) begin
            ack_valid <= 1'b0;
            ack_pos   <= 1'b0;
            dat_valid <= 1'b0;
            dat_hdr   <= '0;
            dat_pay   <= '0;
            err_flag  <= 1'b0;
        end else begin
            ack_valid <= ev_grant || ev_nack;
            ack_pos   <= ev_grant;
            dat_valid <= ev_fwd;
            if (ev_fwd) begin
                dat_hdr <= f.hdr;
                dat_pay <= f.pay;
            end
            err_flag  <= err_flag || ev_err;
        end
    end

    // R3
    grant_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ARB && arb_gnt) |=> (ack_valid && ack_pos && arb_req));

    // R7
    fwd_only_rsv_chk: assert property (@(posedge clk) disable iff (rst)
        dat_valid |-> ($past(state) == ST_RSV));

    // R8
    rel_once_chk: assert property (@(posedge clk) disable iff (rst)
        rel_pulse |=> (!rel_pulse && !arb_req));

    // R10
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        err_flag |=> err_flag);
endmodule

// File: tb/path_rsv_ctrl_tb.sv
module path_rsv_ctrl_tb;
    localparam int TMO_W = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [TMO_W-1:0] tmo_lim = 8'd3;
    logic             in_valid = 1'b0;
    logic             in_ready;
    logic [23:0]      in_flit = '0;
    logic             arb_req;
    logic             arb_gnt = 1'b0;
    logic             ack_valid, ack_pos, rel_pulse, dat_valid, err_flag;
    logic [5:0]       dat_hdr;
    logic [15:0]      dat_pay;

    int errors = 0;
    int checks = 0;
    int seq    = 0;

    always #2 clk = ~clk;

    path_rsv_ctrl #(.TMO_W(TMO_W)) u_dut (
        .clk(clk), .rst(rst), .tmo_lim(tmo_lim),
        .in_valid(in_valid), .in_ready(in_ready), .in_flit(in_flit),
        .arb_req(arb_req), .arb_gnt(arb_gnt),
        .ack_valid(ack_valid), .ack_pos(ack_pos), .rel_pulse(rel_pulse),
        .dat_valid(dat_valid), .dat_hdr(dat_hdr), .dat_pay(dat_pay),
        .err_flag(err_flag)
    );

    // behavioural reference: 0 idle, 1 waiting, 2 open, 3 closing
    int          ms = 0, mc = 0;
    logic        e_ackv = 0, e_ackp = 0, e_dv = 0, e_err = 0;
    logic [5:0]  e_dh = 0;
    logic [15:0] e_dp = 0;

    function automatic int lim_eff();
        return (tmo_lim == 0) ? 1 : int'(tmo_lim);
    endfunction

    function automatic logic exp_ready();
        return !(ms == 1 && (arb_gnt || mc + 1 >= lim_eff()));
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            ms = 0; mc = 0; e_ackv = 0; e_ackp = 0; e_dv = 0; e_err = 0;
        end else begin
            int   nms;
            logic acc;
            int   t;
            acc = in_valid && exp_ready();
            t = int'(in_flit[23:22]);
            nms = ms;
            e_ackv = 0; e_ackp = 0; e_dv = 0;
            if (ms == 1) begin
                if (arb_gnt) begin e_ackv = 1; e_ackp = 1; nms = 2; end
                else if (mc + 1 >= lim_eff()) begin e_ackv = 1; nms = 0; end
                else mc = mc + 1;
            end
            if (ms == 3) nms = 0;
            if (acc) begin
                if (t == 0) begin
                    if (ms == 0) begin nms = 1; mc = 0; end
                    else begin e_ackv = 1; e_ackp = 0; end
                end else if (t == 1 || t == 2) begin
                    if (ms == 2) begin
                        e_dv = 1; e_dh = in_flit[21:16]; e_dp = in_flit[15:0];
                        if (t == 2) nms = 3;
                    end else e_err = 1;
                end else if (ms == 2) nms = 3;
            end
            ms = nms;
        end
    end

    task automatic chk(input string req, input string nm, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, nm, act, exp);
        end
    endtask

    task automatic compare_all();
        chk("R6", "in_ready", 32'(in_ready), 32'(exp_ready()));
        chk("R2", "arb_req", 32'(arb_req), 32'(ms == 1 || ms == 2));
        chk("R8/R9", "rel_pulse", 32'(rel_pulse), 32'(ms == 3));
        chk("R3/R4/R5", "ack_valid", 32'(ack_valid), 32'(e_ackv));
        if (e_ackv) chk("R3/R4/R5", "ack_pos", 32'(ack_pos), 32'(e_ackp));
        chk("R7", "dat_valid", 32'(dat_valid), 32'(e_dv));
        if (e_dv) begin
            chk("R7", "dat_hdr", 32'(dat_hdr), 32'(e_dh));
            chk("R7", "dat_pay", 32'(dat_pay), 32'(e_dp));
        end
        chk("R10", "err_flag", 32'(err_flag), 32'(e_err));
    endtask

    // one cycle: compare at the falling edge, then drive the next inputs
    task automatic cyc(input logic v, input logic [1:0] t, input logic g);
        @(negedge clk);
        compare_all();
        seq++;
        in_valid = v;
        in_flit  = {t, 6'(seq * 5), 16'(seq * 16'h1357)};
        arb_gnt  = g;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 2'b00, 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        idle(3);
        @(negedge clk);
        compare_all();
        // R1 reset state
        chk("R1", "arb_req", 32'(arb_req), 0);
        chk("R1", "ack_valid", 32'(ack_valid), 0);
        chk("R1", "in_ready", 32'(in_ready), 1);
        chk("R1", "err_flag", 32'(err_flag), 0);
        rst = 1'b0;
        idle(2);

        // grant after one waiting cycle, data, busy request, last data (R3 R5 R7 R8)
        tmo_lim = 8'd3;
        cyc(1, 2'b00, 0);
        cyc(0, 2'b00, 0);
        cyc(0, 2'b00, 1);
        cyc(1, 2'b01, 0);
        chk("R3", "ack_pos", 32'(ack_pos), 1);
        cyc(0, 2'b00, 0);
        cyc(1, 2'b01, 0);
        cyc(1, 2'b00, 0);
        cyc(1, 2'b01, 0);
        chk("R5", "ack_pos", 32'(ack_pos), 0);
        chk("R5", "arb_req", 32'(arb_req), 1);
        cyc(1, 2'b10, 0);
        cyc(0, 2'b00, 0);
        chk("R8", "rel_pulse", 32'(rel_pulse), 1);
        idle(2);

        // timeout with a request landing mid-wait and at resolution (R4 R5 R6)
        cyc(1, 2'b00, 0);
        cyc(1, 2'b00, 0);
        cyc(1, 2'b00, 0);
        cyc(1, 2'b00, 0);
        cyc(0, 2'b00, 0);
        idle(3);

        // grant in the last allowed waiting cycle (R4)
        cyc(1, 2'b00, 0);
        cyc(0, 2'b00, 0);
        cyc(0, 2'b00, 0);
        cyc(0, 2'b00, 1);
        cyc(0, 2'b00, 0);
        chk("R4", "ack_pos", 32'(ack_pos), 1);
        cyc(1, 2'b11, 0);
        cyc(0, 2'b00, 0);
        chk("R9", "rel_pulse", 32'(rel_pulse), 1);
        chk("R9", "dat_valid", 32'(dat_valid), 0);
        idle(2);

        // zero limit behaves as one cycle (R4)
        tmo_lim = 8'd0;
        cyc(1, 2'b00, 0);
        cyc(0, 2'b00, 0);
        cyc(0, 2'b00, 0);
        chk("R4", "ack_valid", 32'(ack_valid), 1);
        idle(2);

        // stray end marker and grant while idle (R11 R12)
        cyc(1, 2'b11, 0);
        cyc(0, 2'b00, 1);
        cyc(0, 2'b00, 0);
        chk("R11", "err_flag", 32'(err_flag), 0);
        chk("R11", "ack_valid", 32'(ack_valid), 0);
        chk("R12", "arb_req", 32'(arb_req), 0);
        idle(2);

        // data while idle sets the sticky flag (R10)
        cyc(1, 2'b01, 0);
        cyc(0, 2'b00, 0);
        idle(4);
        chk("R10", "err_flag", 32'(err_flag), 1);

        // random stream against the model
        for (int i = 0; i < 3000; i++) begin
            if (i % 200 == 0) tmo_lim = 8'($urandom % 6);
            cyc(1'($urandom % 2), 2'($urandom % 4), 1'(($urandom % 4) == 0));
        end
        idle(3);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule